// File: doc/BRIEF.md
# Second-Level Buffer Occupancy Throttle

This block watches how full a deep event buffer is while its events wait for a slow second-level trigger decision. A strobe for each stored event and a strobe for each released event keep an occupancy count. When the count reaches a programmable nearly-full threshold, the block raises a throttle that holds off further first-level triggers. It does not store any event data.

Second-level decisions pass through the block with one cycle of latency. Two conditions turn an accept into a reject: a nearly-full signal from a downstream derandomizer or output buffer, and a decision that comes too soon after the previous one. A decision that comes too soon also sets a sticky error flag. Overflow and underflow of the occupancy count are detected and reported as sticky error flags, so that a control fault cannot pass unnoticed.

Top module: `l2_occupancy_throttle`

## Requirements
- R1: After synchronous reset: the throttle is low, all error flags are 0, no decision is output, and the threshold reads back as THR_DEFAULT.
- R2: The occupancy rises by one for a cycle with only `ev_stored` high. It falls by one for a cycle with only `ev_freed` high. It is unchanged when both strobes or neither are high.
- R3: `l1_throttle` is high exactly when occupancy >= threshold, evaluated on the state after the latest clock edge. A threshold of 0 therefore throttles at all times.
- R4: A cycle with `thr_wr_en` high loads `thr_wr_data` into the threshold. `thr_rd` shows the new value after that edge.
- R5: A decision strobe (`l2_dec_valid`) produces `l2_out_valid` on the next cycle. The accept bit passes through unchanged when no rewrite condition applies.
- R6: If `ds_nearly_full` is high in the cycle of a decision, the output decision is a reject. A reject input always stays a reject.
- R7: A decision arriving fewer than MIN_SPACING cycles after the previous decision is output as a reject and sets `err_flags[2]` (sticky). A spacing of exactly MIN_SPACING is legal. The first decision after reset is never a violation.
- R8: A store-only cycle at occupancy MAX_EVENTS sets `err_flags[0]` (sticky) and leaves the occupancy at MAX_EVENTS.
- R9: A release-only cycle at occupancy 0 sets `err_flags[1]` (sticky) and leaves the occupancy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_stored | input | 1 | One event written into the buffer this cycle |
| ev_freed | input | 1 | One event released from the buffer this cycle |
| l2_dec_valid | input | 1 | Second-level decision strobe |
| l2_dec_accept | input | 1 | Accept bit of the decision (1 = accept) |
| ds_nearly_full | input | 1 | Downstream buffer nearly full |
| thr_wr_en | input | 1 | Threshold write enable |
| thr_wr_data | input | CNT_W | New threshold value |
| thr_rd | output | CNT_W | Threshold readback |
| l1_throttle | output | 1 | Hold off first-level triggers |
| l2_out_valid | output | 1 | Rewritten decision valid |
| l2_out_accept | output | 1 | Rewritten decision accept bit |
| err_flags | output | 3 | Sticky errors: bit0 overflow, bit1 underflow, bit2 spacing |

## Verification
The bench builds the block with MAX_EVENTS = 12, MIN_SPACING = 6 and THR_DEFAULT = 10. With these values the bench can fill the buffer to its limit and push one event past it, then drain it to zero and release one more. Both saturation edges and the sticky flags can be reached in a few dozen cycles. The short spacing window lets decisions land at exactly the minimum gap and one cycle inside it, mixed with downstream backpressure. A scoreboard queue carries the expected accept bit of each decision.

// File: rtl/l2thr_pkg.sv
package l2thr_pkg;

    // Error flag bundle; packed so that bit0 = overflow, bit1 = underflow, bit2 = spacing
    typedef struct packed {
        logic spacing;
        logic underflow;
        logic overflow;
    } err_flags_t;

    // One rewritten second-level decision
    typedef struct packed {
        logic valid;
        logic accept;
    } decision_t;

    // Occupancy update selected by the two strobes
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_op_t;

    function automatic occ_op_t occ_decode(input logic stored, input logic freed);
        occ_op_t op;
        unique case ({stored, freed})
            2'b10:   op = OCC_INC;
            2'b01:   op = OCC_DEC;
            default: op = OCC_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/l2thr_occupancy.sv
module l2thr_occupancy
    import l2thr_pkg::*;
#(
    parameter int MAX_EVENTS = 1000,
    parameter int CNT_W      = $clog2(MAX_EVENTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_stored,
    input  logic             ev_freed,
    output logic [CNT_W-1:0] occ,
    output logic             ovf_err,
    output logic             unf_err
);

    localparam logic [CNT_W-1:0] OCC_LIMIT = CNT_W'(MAX_EVENTS);

    occ_op_t op;

    always_comb op = occ_decode(ev_stored, ev_freed);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ     <= '0;
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            unique case (op)
                OCC_INC: begin
                    if (occ == OCC_LIMIT) ovf_err <= 1'b1;
                    else                  occ     <= occ + CNT_W'(1);
                end
                OCC_DEC: begin
                    if (occ == '0) unf_err <= 1'b1;
                    else           occ     <= occ - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // R2: a store-only cycle below the limit adds exactly one
    p_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OCC_INC && occ < OCC_LIMIT) |=> occ == $past(occ) + CNT_W'(1));

    // R2: simultaneous store and release leave the count alone
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_stored && ev_freed) |=> $stable(occ));

    // R8: the count never passes the buffer capacity
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_LIMIT);

    // R8: a store at the limit flags overflow and keeps the count
    p_ovf_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OCC_INC && occ == OCC_LIMIT) |=> (ovf_err && occ == OCC_LIMIT));

    // R9: a release at zero flags underflow and keeps the count at zero
    p_unf_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OCC_DEC && occ == '0) |=> (unf_err && occ == '0));

endmodule

// File: rtl/l2thr_threshold.sv
module l2thr_threshold #(
    parameter int CNT_W       = 10,
    parameter int THR_DEFAULT = 960
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] thr
);

    always_ff @(posedge clk) begin
        if (rst)        thr <= CNT_W'(THR_DEFAULT);
        else if (wr_en) thr <= wr_data;
    end

    // R4: a write is visible on the readback after its edge
    p_thr_write_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> thr == $past(wr_data));

endmodule

// File: rtl/l2thr_decision_gate.sv
module l2thr_decision_gate
    import l2thr_pkg::*;
#(
    parameter int MIN_SPACING = 36
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      dec_valid,
    input  logic      dec_accept,
    input  logic      ds_nearly_full,
    output decision_t dec_out,
    output logic      spacing_err
);

    localparam int               GAP_W   = $clog2(MIN_SPACING + 1);
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_SPACING);

    logic [GAP_W-1:0] gap;        // cycles since the last decision, saturating
    logic             seen;       // a decision has occurred since reset
    logic             too_close;

    always_comb too_close = dec_valid && seen && (gap < GAP_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap         <= '0;
            seen        <= 1'b0;
            dec_out     <= '0;
            spacing_err <= 1'b0;
        end else begin
            dec_out.valid  <= dec_valid;
            dec_out.accept <= dec_valid && dec_accept && !ds_nearly_full && !too_close;
            if (dec_valid) begin
                gap  <= GAP_W'(1);
                seen <= 1'b1;
            end else if (gap < GAP_MIN) begin
                gap <= gap + GAP_W'(1);
            end
            if (too_close) spacing_err <= 1'b1;
        end
    end

    // R5: every decision strobe is answered on the next cycle
    p_forward_r5: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> dec_out.valid);

    // R5: no output decision without an input strobe
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> !dec_out.valid);

    // R6: downstream backpressure never lets an accept through
    p_backpressure_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && ds_nearly_full) |=> !dec_out.accept);

    // R6: a reject is never promoted to an accept
    p_reject_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |=> !dec_out.accept);

    // R7: a decision inside the spacing window is rejected and flagged
    p_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        too_close |=> (spacing_err && !dec_out.accept));

    // R7: the spacing flag is sticky
    p_spacing_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        spacing_err |=> spacing_err);

endmodule

// File: rtl/l2_occupancy_throttle.sv
module l2_occupancy_throttle
    import l2thr_pkg::*;
#(
    parameter int MAX_EVENTS  = 1000,
    parameter int MIN_SPACING = 36,
    parameter int THR_DEFAULT = 960,
    localparam int CNT_W      = $clog2(MAX_EVENTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_stored,
    input  logic             ev_freed,
    input  logic             l2_dec_valid,
    input  logic             l2_dec_accept,
    input  logic             ds_nearly_full,
    input  logic             thr_wr_en,
    input  logic [CNT_W-1:0] thr_wr_data,
    output logic [CNT_W-1:0] thr_rd,
    output logic             l1_throttle,
    output logic             l2_out_valid,
    output logic             l2_out_accept,
    output logic [2:0]       err_flags
);

    logic [CNT_W-1:0] occ;
    logic             ovf_err;
    logic             unf_err;
    logic             spacing_err;
    decision_t        dec_out;
    err_flags_t       errs;

    l2thr_occupancy #(
        .MAX_EVENTS (MAX_EVENTS),
        .CNT_W      (CNT_W)
    ) u_occ (
        .clk       (clk),
        .rst       (rst),
        .ev_stored (ev_stored),
        .ev_freed  (ev_freed),
        .occ       (occ),
        .ovf_err   (ovf_err),
        .unf_err   (unf_err)
    );

    l2thr_threshold #(
        .CNT_W       (CNT_W),
        .THR_DEFAULT (THR_DEFAULT)
    ) u_thr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (thr_wr_en),
        .wr_data (thr_wr_data),
        .thr     (thr_rd)
    );

    l2thr_decision_gate #(
        .MIN_SPACING (MIN_SPACING)
    ) u_gate (
        .clk            (clk),
        .rst            (rst),
        .dec_valid      (l2_dec_valid),
        .dec_accept     (l2_dec_accept),
        .ds_nearly_full (ds_nearly_full),
        .dec_out        (dec_out),
        .spacing_err    (spacing_err)
    );

    always_comb begin
        l1_throttle     = (occ >= thr_rd);
        l2_out_valid    = dec_out.valid;
        l2_out_accept   = dec_out.accept;
        errs.overflow   = ovf_err;
        errs.underflow  = unf_err;
        errs.spacing    = spacing_err;
        err_flags       = errs;
    end

    // R3: the throttle cannot drop unless an event left or the threshold was rewritten
    p_throttle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (l1_throttle && !ev_freed && !thr_wr_en) |=> l1_throttle);

    // R3: the throttle cannot rise unless an event arrived or the threshold was rewritten
    p_throttle_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (!l1_throttle && !ev_stored && !thr_wr_en) |=> !l1_throttle);

endmodule

// File: tb/tb_l2_occupancy_throttle.sv
module tb_l2_occupancy_throttle;

    localparam int MAXE  = 12;
    localparam int MINSP = 6;
    localparam int THRD  = 10;
    localparam int CW    = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_stored = 1'b0, ev_freed = 1'b0;
    logic          l2_dec_valid = 1'b0, l2_dec_accept = 1'b0, ds_nearly_full = 1'b0;
    logic          thr_wr_en = 1'b0;
    logic [CW-1:0] thr_wr_data = '0;
    logic [CW-1:0] thr_rd;
    logic          l1_throttle, l2_out_valid, l2_out_accept;
    logic [2:0]    err_flags;

    l2_occupancy_throttle #(
        .MAX_EVENTS (MAXE),
        .MIN_SPACING(MINSP),
        .THR_DEFAULT(THRD)
    ) dut (
        .clk(clk), .rst(rst),
        .ev_stored(ev_stored), .ev_freed(ev_freed),
        .l2_dec_valid(l2_dec_valid), .l2_dec_accept(l2_dec_accept),
        .ds_nearly_full(ds_nearly_full),
        .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
        .thr_rd(thr_rd), .l1_throttle(l1_throttle),
        .l2_out_valid(l2_out_valid), .l2_out_accept(l2_out_accept),
        .err_flags(err_flags)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model
    int m_occ = 0;
    int m_thr = THRD;
    bit m_ovf = 0, m_unf = 0, m_spc = 0;
    int pcyc = 0;
    int last_dec = 0;
    bit m_seen = 0;
    bit exp_q[$];

    always @(posedge clk) pcyc <= pcyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for every decision the design emits
    always @(negedge clk) begin
        if (!rst && l2_out_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R5: actual unexpected decision expected none");
            end else begin
                bit e;
                e = exp_q.pop_front();
                if (l2_out_accept !== e) begin
                    fails++;
                    $display("FAIL R5/R6/R7: actual accept %0d expected %0d", l2_out_accept, e);
                end
            end
        end
    end

    task automatic step(input bit st, input bit fr);
        ev_stored = st;
        ev_freed  = fr;
        if (st && !fr) begin
            if (m_occ == MAXE) m_ovf = 1; else m_occ++;
        end else if (fr && !st) begin
            if (m_occ == 0) m_unf = 1; else m_occ--;
        end
        @(negedge clk);
        ev_stored = 1'b0;
        ev_freed  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_thr(input int v);
        thr_wr_en   = 1'b1;
        thr_wr_data = CW'(v);
        m_thr       = v;
        @(negedge clk);
        thr_wr_en   = 1'b0;
    endtask

    // driver: computes the expected accept bit and queues it
    task automatic decide(input bit acc, input bit dsnf);
        bit close;
        close = m_seen && ((pcyc - last_dec) < MINSP);
        if (close) m_spc = 1;
        exp_q.push_back(acc && !dsnf && !close);
        m_seen   = 1;
        last_dec = pcyc;
        l2_dec_valid   = 1'b1;
        l2_dec_accept  = acc;
        ds_nearly_full = dsnf;
        @(negedge clk);
        l2_dec_valid   = 1'b0;
        l2_dec_accept  = 1'b0;
        ds_nearly_full = 1'b0;
    endtask

    task automatic chk_state(input string req);
        chk({req, " throttle"}, int'(l1_throttle), int'(m_occ >= m_thr));
        chk({req, " errors"}, int'(err_flags), int'({m_spc, m_unf, m_ovf}));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 thr_rd", int'(thr_rd), THRD);
        chk("R1 throttle", int'(l1_throttle), 0);
        chk("R1 err_flags", int'(err_flags), 0);
        chk("R1 out_valid", int'(l2_out_valid), 0);

        // R4 threshold write and readback
        wr_thr(4);
        chk("R4 thr_rd", int'(thr_rd), 4);
        wr_thr(3);
        chk("R4 thr_rd", int'(thr_rd), 3);

        // R2 / R3 counting against threshold 3
        step(1, 0); chk_state("R2");
        step(1, 0); chk_state("R2");
        step(1, 0); chk_state("R3 reach threshold");
        chk("R3 throttle at 3", int'(l1_throttle), 1);
        step(1, 1); chk_state("R2 both strobes");
        chk("R2 both strobes keeps throttle", int'(l1_throttle), 1);
        step(0, 1); chk_state("R2 release");
        chk("R3 throttle below", int'(l1_throttle), 0);
        step(0, 0); chk_state("R2 idle");

        // R5 / R6 / R7 decisions
        decide(1, 0);          // first decision, accept passes
        idle(MINSP);
        decide(0, 0);          // reject stays reject
        idle(MINSP);
        decide(1, 1);          // backpressure rewrites accept
        idle(MINSP - 1);
        decide(1, 0);          // exactly MINSP apart: legal
        idle(1);
        chk_state("R7 exact spacing no error");
        decide(1, 0);          // 2 cycles apart: violation
        idle(1);
        chk_state("R7 violation flagged");
        chk("R7 spacing bit", int'(err_flags[2]), 1);
        idle(MINSP);
        decide(1, 0);          // legal again, error stays sticky
        idle(2);
        chk_state("R7 sticky");

        // R8 overflow
        wr_thr(MAXE);
        while (m_occ < MAXE) step(1, 0);
        chk_state("R8 full");
        step(1, 0);
        chk_state("R8 overflow");
        chk("R8 overflow bit", int'(err_flags[0]), 1);
        step(0, 1);
        chk("R8 count held at limit", int'(l1_throttle), 0);
        step(1, 0);
        chk("R8 back at limit", int'(l1_throttle), 1);

        // R9 underflow
        while (m_occ > 0) step(0, 1);
        chk_state("R9 empty");
        step(0, 1);
        chk_state("R9 underflow");
        chk("R9 underflow bit", int'(err_flags[1]), 1);
        wr_thr(1);
        chk("R9 zero held", int'(l1_throttle), 0);
        step(1, 0);
        chk("R9 one event", int'(l1_throttle), 1);

        // R3 threshold zero throttles an empty buffer
        step(0, 1);
        wr_thr(0);
        chk_state("R3 zero threshold");
        chk("R3 zero threshold throttle", int'(l1_throttle), 1);

        idle(3);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule